// File: doc/BRIEF.md
# Guarded Word Store Unit

This block sits in a load/store pipe and turns one predicated 32-bit store into a memory write. Each issued store carries a base register value, a signed displacement field counted in words, the data word, a guard register value and a byte-order select. If the guard's lowest bit is set and the computed effective address (EA) falls on a word boundary, the block registers a word-address write with all four byte strobes on. The data bytes are placed in address order for the selected byte order.

A guarded store whose EA is not word aligned writes nothing. Instead it raises a sticky misalignment flag. When trap reporting is enabled, it also latches a pending trap request. That request is offered at the next interruptible jump and stays pending until that jump acknowledges it. A store whose guard bit is clear leaves every output and every flag as it was.

The memory side is a valid/ready write port. The issue side sees a ready that is high whenever the output register is empty or is being drained in the same cycle.

Top module: `gstore_unit`

## Requirements
- R1: EA is base_val plus the sign-extended 7-bit disp_fld times 4, wrapping modulo 2^32; mem_waddr carries EA[31:2].
- R2: Lane j of mem_wdata is bits [8j+7:8j] and holds the byte for address EA+j. With big_endian=1, lane 0 holds wdata[31:24] and lane 3 holds wdata[7:0].
- R3: With big_endian=0, lane j holds wdata[8j+7:8j], so mem_wdata equals wdata.
- R4: mem_be is 4'b1111 whenever mem_valid is high.
- R5: Only guard_val[0] decides a store. When it is 0 and the store is accepted, there is no write, mis_flag does not change and trap_pend does not change, whatever the other guard bits are.
- R6: A guarded accepted store with EA[1:0] not zero makes no write and sets mis_flag in the next cycle.
- R7: mis_flag stays set until a cycle with stat_clr high. A misaligned store accepted in the same cycle as stat_clr leaves the flag set.
- R8: A misaligned guarded store accepted while trap_en is 1 sets trap_pend. trap_take is high while trap_pend and jump_strobe are both high. trap_pend clears only in a cycle where jump_strobe and trap_ack are both high.
- R9: While mem_valid is high and mem_ready is low, mem_valid, mem_waddr and mem_wdata hold and iss_ready is low. Otherwise iss_ready is high.
- R10: A synchronous active-high rst clears mem_valid, mis_flag and trap_pend at the next clock edge.
- R11: An aligned guarded store accepted at a clock edge drives mem_valid high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A store is presented |
| iss_ready | output | 1 | The store can be accepted this cycle |
| base_val | input | 32 | Base register value |
| disp_fld | input | 7 | Signed displacement in words |
| wdata | input | 32 | Word to store |
| guard_val | input | 32 | Guard register value; only bit 0 is used |
| big_endian | input | 1 | 1 selects big-endian lane order, 0 selects little-endian |
| trap_en | input | 1 | Enable for the deferred misalignment trap |
| stat_clr | input | 1 | Clears the sticky misalignment flag |
| jump_strobe | input | 1 | An interruptible jump is executing |
| trap_ack | input | 1 | The jump takes the pending trap |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_waddr | output | 30 | Word address of the write |
| mem_be | output | 4 | Byte strobes |
| mem_wdata | output | 32 | Lane-ordered write data |
| mis_flag | output | 1 | Sticky misaligned-store flag |
| trap_pend | output | 1 | Pending misalignment trap |
| trap_take | output | 1 | Trap offered to the current interruptible jump |

## Verification
The properties assume rst is asserted from time zero until the first edge. They also assume every input is known and stable around each rising edge. Misalignment is judged from the two low bits of base_val alone, which is valid only because the displacement is always a whole number of words. The bench drives every input at the falling edge and keeps disp_fld within its 7-bit field. It changes mem_ready only between edges, so a store is taken exactly when iss_valid meets iss_ready.

// File: rtl/gstore_pkg.sv
package gstore_pkg;
   typedef enum logic {
      ORDER_LITTLE = 1'b0,
      ORDER_BIG    = 1'b1
   } byte_order_e;

   // index of the source byte (counted from the least significant end)
   // that lands in address lane "lane" for a word of nbytes bytes
   function automatic int unsigned lane_source(input int unsigned lane,
                                               input int unsigned nbytes,
                                               input byte_order_e order);
      int unsigned flip;
      flip = (order == ORDER_LITTLE) ? (nbytes - 1) : 0;
      return (nbytes - 1) - (lane ^ flip);
   endfunction
endpackage

// File: rtl/gstore_addr_gen.sv
module gstore_addr_gen #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DISP_W     = 7,
   parameter int unsigned SCALE_LOG2 = 2,
   parameter int unsigned LANE_BITS  = 2
) (
   input  logic [ADDR_W-1:0]           base_i,
   input  logic [DISP_W-1:0]           disp_i,
   output logic [ADDR_W-LANE_BITS-1:0] waddr_o,
   output logic                        misaligned_o
);
   logic [ADDR_W-1:0] disp_sx;
   logic [ADDR_W-1:0] disp_scaled;
   logic [ADDR_W-1:0] eff_addr;

   if (DISP_W + SCALE_LOG2 > ADDR_W) begin : g_bad_disp
      $error("gstore_addr_gen: displacement wider than address");
   end

   assign disp_sx     = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
   assign disp_scaled = disp_sx << SCALE_LOG2;
   assign eff_addr    = base_i + disp_scaled;

   assign waddr_o      = eff_addr[ADDR_W-1:LANE_BITS];
   assign misaligned_o = |eff_addr[LANE_BITS-1:0];
endmodule

// File: rtl/gstore_lane_map.sv
module gstore_lane_map
   import gstore_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] data_i,
   input  byte_order_e       order_i,
   output logic [DATA_W-1:0] lanes_o
);
   localparam int unsigned NBYTES = DATA_W / 8;

   for (genvar j = 0; j < NBYTES; j++) begin : g_lane
      localparam int unsigned SRC_LE = lane_source(j, NBYTES, ORDER_LITTLE);
      localparam int unsigned SRC_BE = lane_source(j, NBYTES, ORDER_BIG);
      assign lanes_o[8*j +: 8] = (order_i == ORDER_BIG) ? data_i[8*SRC_BE +: 8]
                                                        : data_i[8*SRC_LE +: 8];
   end
endmodule

// File: rtl/gstore_status.sv
module gstore_status (
   input  logic clk,
   input  logic rst,
   input  logic mis_evt_i,
   input  logic trap_en_i,
   input  logic stat_clr_i,
   input  logic jump_i,
   input  logic ack_i,
   output logic mis_flag_o,
   output logic trap_pend_o,
   output logic trap_take_o
);
   logic mis_q;
   logic pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mis_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         // a new event has priority over a clear in the same cycle
         if (mis_evt_i)
            mis_q <= 1'b1;
         else if (stat_clr_i)
            mis_q <= 1'b0;

         if (mis_evt_i && trap_en_i)
            pend_q <= 1'b1;
         else if (jump_i && ack_i)
            pend_q <= 1'b0;
      end
   end

   assign mis_flag_o  = mis_q;
   assign trap_pend_o = pend_q;
   assign trap_take_o = pend_q & jump_i;
endmodule

// File: rtl/gstore_unit.sv
module gstore_unit
   import gstore_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DISP_W = 7
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  iss_valid,
   output logic                                  iss_ready,
   input  logic [ADDR_W-1:0]                     base_val,
   input  logic [DISP_W-1:0]                     disp_fld,
   input  logic [DATA_W-1:0]                     wdata,
   input  logic [DATA_W-1:0]                     guard_val,
   input  logic                                  big_endian,
   input  logic                                  trap_en,
   input  logic                                  stat_clr,
   input  logic                                  jump_strobe,
   input  logic                                  trap_ack,
   output logic                                  mem_valid,
   input  logic                                  mem_ready,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    mem_waddr,
   output logic [DATA_W/8-1:0]                   mem_be,
   output logic [DATA_W-1:0]                     mem_wdata,
   output logic                                  mis_flag,
   output logic                                  trap_pend,
   output logic                                  trap_take
);
   localparam int unsigned NBYTES    = DATA_W / 8;
   localparam int unsigned LANE_BITS = $clog2(NBYTES);
   localparam int unsigned WADDR_W   = ADDR_W - LANE_BITS;

   if (DATA_W % 8 != 0 || NBYTES < 2 || (1 << LANE_BITS) != NBYTES) begin : g_bad_data
      $error("gstore_unit: DATA_W must be a power-of-two number of bytes");
   end
   if (DISP_W < 2) begin : g_bad_disp
      $error("gstore_unit: DISP_W too small");
   end

   logic [WADDR_W-1:0] waddr_c;
   logic               misaligned_c;
   logic [DATA_W-1:0]  lanes_c;
   logic               accept;
   logic               guard_ok;
   logic               do_write;
   logic               mis_evt;
   logic               unused_guard;

   logic               valid_q;
   logic [WADDR_W-1:0] waddr_q;
   logic [DATA_W-1:0]  wdata_q;

   gstore_addr_gen #(
      .ADDR_W    (ADDR_W),
      .DISP_W    (DISP_W),
      .SCALE_LOG2(LANE_BITS),
      .LANE_BITS (LANE_BITS)
   ) u_addr (
      .base_i      (base_val),
      .disp_i      (disp_fld),
      .waddr_o     (waddr_c),
      .misaligned_o(misaligned_c)
   );

   gstore_lane_map #(
      .DATA_W(DATA_W)
   ) u_lanes (
      .data_i (wdata),
      .order_i(byte_order_e'(big_endian)),
      .lanes_o(lanes_c)
   );

   assign unused_guard = ^guard_val[DATA_W-1:1];
   assign guard_ok     = guard_val[0];
   assign iss_ready    = !valid_q || mem_ready;
   assign accept       = iss_valid && iss_ready;
   assign do_write     = accept && guard_ok && !misaligned_c;
   assign mis_evt      = accept && guard_ok && misaligned_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
      end else if (do_write) begin
         valid_q <= 1'b1;
      end else if (mem_ready) begin
         valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (do_write) begin
         waddr_q <= waddr_c;
         wdata_q <= lanes_c;
      end
   end

   gstore_status u_status (
      .clk        (clk),
      .rst        (rst),
      .mis_evt_i  (mis_evt),
      .trap_en_i  (trap_en),
      .stat_clr_i (stat_clr),
      .jump_i     (jump_strobe),
      .ack_i      (trap_ack),
      .mis_flag_o (mis_flag),
      .trap_pend_o(trap_pend),
      .trap_take_o(trap_take)
   );

   assign mem_valid = valid_q;
   assign mem_waddr = waddr_q;
   assign mem_wdata = wdata_q;
   assign mem_be    = valid_q ? {NBYTES{1'b1}} : {NBYTES{1'b0}};
endmodule

// File: rtl/gstore_unit_chk.sv
module gstore_unit_chk #(
   parameter int unsigned WADDR_W   = 30,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LANE_BITS = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 iss_valid,
   input logic                 iss_ready,
   input logic                 guard0,
   input logic [LANE_BITS-1:0] base_lo,
   input logic                 trap_en,
   input logic                 stat_clr,
   input logic                 jump_strobe,
   input logic                 trap_ack,
   input logic                 mem_valid,
   input logic                 mem_ready,
   input logic [WADDR_W-1:0]   mem_waddr,
   input logic [DATA_W-1:0]    mem_wdata,
   input logic                 mis_flag,
   input logic                 trap_pend
);
   logic acc;
   logic mis;
   assign acc = iss_valid && iss_ready;
   assign mis = base_lo != '0;

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (!mem_valid && !mis_flag && !trap_pend));

   p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_waddr) && $stable(mem_wdata)));

   p_false_guard_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
      (acc && !guard0) |=> !mem_valid);

   p_false_guard_noflag_r5: assert property (@(posedge clk) disable iff (rst)
      (acc && !guard0 && !mis_flag && !trap_pend) |=> (!mis_flag && !trap_pend));

   p_misaligned_flag_r6: assert property (@(posedge clk) disable iff (rst)
      (acc && guard0 && mis) |=> (mis_flag && !mem_valid));

   p_aligned_write_r11: assert property (@(posedge clk) disable iff (rst)
      (acc && guard0 && !mis) |=> mem_valid);

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (mis_flag && !stat_clr) |=> mis_flag);

   p_trap_set_r8: assert property (@(posedge clk) disable iff (rst)
      (acc && guard0 && mis && trap_en) |=> trap_pend);

   p_trap_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (trap_pend && !(jump_strobe && trap_ack)) |=> trap_pend);
endmodule

bind gstore_unit gstore_unit_chk #(
   .WADDR_W  (WADDR_W),
   .DATA_W   (DATA_W),
   .LANE_BITS(LANE_BITS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .iss_valid  (iss_valid),
   .iss_ready  (iss_ready),
   .guard0     (guard_val[0]),
   .base_lo    (base_val[LANE_BITS-1:0]),
   .trap_en    (trap_en),
   .stat_clr   (stat_clr),
   .jump_strobe(jump_strobe),
   .trap_ack   (trap_ack),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_waddr  (mem_waddr),
   .mem_wdata  (mem_wdata),
   .mis_flag   (mis_flag),
   .trap_pend  (trap_pend)
);

// File: tb/gstore_unit_tb_top.sv
module gstore_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        iss_valid = 1'b0;
   logic        iss_ready;
   logic [31:0] base_val = '0;
   logic [6:0]  disp_fld = '0;
   logic [31:0] wdata = '0;
   logic [31:0] guard_val = '0;
   logic        big_endian = 1'b0;
   logic        trap_en = 1'b0;
   logic        stat_clr = 1'b0;
   logic        jump_strobe = 1'b0;
   logic        trap_ack = 1'b0;
   logic        mem_valid;
   logic        mem_ready = 1'b1;
   logic [29:0] mem_waddr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mis_flag;
   logic        trap_pend;
   logic        trap_take;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   gstore_unit dut_i (
      .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .base_val(base_val), .disp_fld(disp_fld), .wdata(wdata), .guard_val(guard_val),
      .big_endian(big_endian), .trap_en(trap_en), .stat_clr(stat_clr),
      .jump_strobe(jump_strobe), .trap_ack(trap_ack), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_waddr(mem_waddr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mis_flag(mis_flag), .trap_pend(trap_pend),
      .trap_take(trap_take)
   );

   typedef struct packed {
      logic [31:0] base;
      logic [6:0]  disp;
      logic [31:0] data;
      logic [31:0] guard;
      logic        be;
      logic [29:0] exp_waddr;
      logic [31:0] exp_wdata;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'h00000cfc, 7'h01, 32'h44332211, 32'h00000001, 1'b1, 30'h340,      32'h11223344},
      '{32'h00000d0c, 7'h7e, 32'haabbccdd, 32'h00000003, 1'b1, 30'h341,      32'hddccbbaa},
      '{32'h00001000, 7'h00, 32'h12345678, 32'h80000001, 1'b0, 30'h400,      32'h12345678},
      '{32'h00000100, 7'h40, 32'hcafef00d, 32'h00000001, 1'b0, 30'h000,      32'hcafef00d},
      '{32'h00000000, 7'h3f, 32'hdeadbeef, 32'hffffffff, 1'b1, 30'h03f,      32'hefbeadde},
      '{32'h00000000, 7'h7f, 32'h0badf00d, 32'h00000001, 1'b0, 30'h3fffffff, 32'h0badf00d},
      '{32'hfffffffc, 7'h01, 32'h01020304, 32'h00000005, 1'b1, 30'h000,      32'h04030201}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after acceptance
   task automatic issue(input logic [31:0] b, input logic [6:0] d, input logic [31:0] dat,
                        input logic [31:0] g, input logic be);
      base_val = b; disp_fld = d; wdata = dat; guard_val = g; big_endian = be;
      iss_valid = 1'b1;
      @(negedge clk);
      iss_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R10: reset state
      chk("R10", "mem_valid", 32'(mem_valid), 32'd0);
      chk("R10", "mis_flag",  32'(mis_flag),  32'd0);
      chk("R10", "trap_pend", 32'(trap_pend), 32'd0);
      chk("R9",  "iss_ready idle", 32'(iss_ready), 32'd1);

      // table: R1 address, R2/R3 lanes, R4 strobes, R11 timing
      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].base, VECS[i].disp, VECS[i].data, VECS[i].guard, VECS[i].be);
         chk("R11", "mem_valid", 32'(mem_valid), 32'd1);
         chk("R1",  "mem_waddr", 32'(mem_waddr), 32'(VECS[i].exp_waddr));
         chk(VECS[i].be ? "R2" : "R3", "mem_wdata", mem_wdata, VECS[i].exp_wdata);
         chk("R4",  "mem_be", 32'(mem_be), 32'hf);
      end
      @(negedge clk);
      chk("R9", "drained", 32'(mem_valid), 32'd0);

      // R5: false guard, aligned, upper guard bits set
      issue(32'h2000, 7'h00, 32'h55555555, 32'hfffffffe, 1'b0);
      chk("R5", "no write", 32'(mem_valid), 32'd0);
      // R5: false guard, misaligned, trap enabled
      trap_en = 1'b1;
      issue(32'h2001, 7'h00, 32'h55555555, 32'h00000000, 1'b0);
      chk("R5", "no mis_flag", 32'(mis_flag), 32'd0);
      chk("R5", "no trap", 32'(trap_pend), 32'd0);
      chk("R5", "no write mis", 32'(mem_valid), 32'd0);
      trap_en = 1'b0;

      // R6: guarded misaligned store, trap disabled
      issue(32'h3002, 7'h01, 32'h66666666, 32'h1, 1'b1);
      chk("R6", "no write", 32'(mem_valid), 32'd0);
      chk("R6", "mis_flag set", 32'(mis_flag), 32'd1);
      chk("R8", "no trap when disabled", 32'(trap_pend), 32'd0);
      repeat (3) @(negedge clk);
      chk("R7", "sticky", 32'(mis_flag), 32'd1);
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      chk("R7", "cleared", 32'(mis_flag), 32'd0);

      // R7: set wins over a simultaneous clear
      stat_clr = 1'b1;
      issue(32'h3003, 7'h00, 32'h0, 32'h1, 1'b0);
      stat_clr = 1'b0;
      chk("R7", "set over clear", 32'(mis_flag), 32'd1);

      // R8: deferred trap
      trap_en = 1'b1;
      issue(32'h4001, 7'h02, 32'h77777777, 32'h1, 1'b0);
      trap_en = 1'b0;
      chk("R8", "trap_pend set", 32'(trap_pend), 32'd1);
      chk("R8", "no take without jump", 32'(trap_take), 32'd0);
      jump_strobe = 1'b1;
      #1;
      chk("R8", "trap_take at jump", 32'(trap_take), 32'd1);
      @(negedge clk);
      jump_strobe = 1'b0;
      chk("R8", "held without ack", 32'(trap_pend), 32'd1);
      jump_strobe = 1'b1; trap_ack = 1'b1;
      @(negedge clk);
      jump_strobe = 1'b0; trap_ack = 1'b0;
      chk("R8", "cleared by ack", 32'(trap_pend), 32'd0);
      trap_ack = 1'b1;
      @(negedge clk);
      trap_ack = 1'b0;
      chk("R7", "flag kept after trap ack", 32'(mis_flag), 32'd1);

      // R9: back-pressure
      mem_ready = 1'b0;
      issue(32'h5000, 7'h03, 32'h89abcdef, 32'h1, 1'b1);
      repeat (2) @(negedge clk);
      chk("R9", "valid held", 32'(mem_valid), 32'd1);
      chk("R9", "addr held", 32'(mem_waddr), 32'h1403);
      chk("R9", "data held", mem_wdata, 32'hefcdab89);
      chk("R9", "iss_ready low", 32'(iss_ready), 32'd0);
      mem_ready = 1'b1;
      @(negedge clk);
      chk("R9", "released", 32'(mem_valid), 32'd0);

      // R10: reset clears raised flags and a pending write
      trap_en = 1'b1;
      issue(32'h6001, 7'h00, 32'h0, 32'h1, 1'b0);
      trap_en = 1'b0;
      mem_ready = 1'b0;
      issue(32'h6000, 7'h00, 32'h0, 32'h1, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      mem_ready = 1'b1;
      chk("R10", "valid cleared", 32'(mem_valid), 32'd0);
      chk("R10", "flag cleared", 32'(mis_flag), 32'd0);
      chk("R10", "trap cleared", 32'(trap_pend), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule